// File: doc/BRIEF.md
# Calendar Timekeeper with Deferred-Commit Busy Flags

This block keeps wall-clock time (hours, minutes, seconds) and a calendar date (day, month, year offset, leap flag). Both advance on a single-cycle slow tick that arrives once per second. Time and date are each held in one packed word, and both words can be read through a small register port. The year field counts from 1970, so its six bits cover 1970 to 2033.

Software writes to the time word or the date word do not take effect at once. An accepted write raises a busy flag for that word in the control word. The new value is held in a staging register and loaded on a later tick, which models the crossing into the slow domain. Until then, reads return the live, still-counting value. Software polls the control word before writing, and once more after writing to learn when the value has landed. Reads are not atomic across the two words, so a time/date pair read around midnight can be inconsistent.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00000101 (day 1, month 1, year offset 0, leap 0), and the control word reads 0.
- R2: The time word at offset 0x14 holds seconds in [5:0], minutes in [13:8] and hours in [20:16]. The date word at offset 0x10 holds day in [4:0], month in [11:8], year offset in [21:16] and leap flag in [22]. All other bits read 0.
- R3: Each tick advances seconds. Seconds wrap after 59 into a minute carry, minutes wrap after 59 into an hour carry, and hours wrap after 23 into a day carry.
- R4: On a day carry, the day wraps to 1 after the last day of its month. That last day is 30 for months 4, 6, 9 and 11, 29 for month 2 with the leap flag set, 28 for month 2 with the flag clear, and 31 otherwise. The leap flag is unchanged unless the year changes.
- R5: Past the last day of month 12, the month becomes 1 and the year offset increments. The leap flag becomes 1 exactly when the new year offset modulo 4 equals 2.
- R6: An accepted write to offset 0x14 sets control bit 8. The time word keeps counting from its old value. On the COMMIT_TICKS-th tick after the write cycle, the time word takes the written value and bit 8 clears in the same cycle.
- R7: An accepted write to offset 0x10 sets control bit 7. The date word keeps its old value and rollover behaviour. On the COMMIT_TICKS-th tick after the write cycle, the date word takes the written value and bit 7 clears.
- R8: A write to a word whose busy flag is set is ignored. The value that lands is the first write's value.
- R9: Control bit 9 always reads 0. Writes to offset 0x00 have no effect, and unmapped offsets read 0.
- R10: On a commit tick the loaded value replaces that tick's advance. A committed time is not incremented, and a committed date wins over a simultaneous day carry.
- R11: With no tick, the time and date words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
A wrong carry or month-length decision corrupts the date word on the tick that crosses midnight. A wrong leap recomputation only appears on the next 28 February of the following year. For this reason the rollover cases are driven directly to the edge of each month and year. A broken commit counter shows up as a busy flag that clears one tick early or late, or as a time word that is one count off on the commit tick. Both are visible on the port at the first read after that tick. An ignored-write fault only appears in the value that finally lands, so the bench checks each committed value.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 6;
  localparam int HMS_W = SEC_W + MIN_W + HR_W;
  localparam int YMD_W = DAY_W + MON_W + YR_W + 1;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_DATE = 8'h10;
  localparam logic [7:0] OFS_TIME = 8'h14;

  localparam int BIT_DATE_BUSY = 7;
  localparam int BIT_TIME_BUSY = 8;
  localparam int BIT_ALRM_BUSY = 9;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sec;
  } hms_t;

  typedef struct packed {
    logic             leap;
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
  } ymd_t;

  function automatic logic [31:0] hms_to_word(input hms_t t);
    logic [31:0] w;
    w        = '0;
    w[5:0]   = t.sec;
    w[13:8]  = t.mn;
    w[20:16] = t.hr;
    return w;
  endfunction

  function automatic logic [31:0] ymd_to_word(input ymd_t d);
    logic [31:0] w;
    w        = '0;
    w[4:0]   = d.day;
    w[11:8]  = d.mon;
    w[21:16] = d.yr;
    w[22]    = d.leap;
    return w;
  endfunction
endpackage

// File: rtl/cal_month_days.sv
module cal_month_days
  import cal_pkg::*;
(
  input  logic [MON_W-1:0] mon_i,
  input  logic             leap_i,
  output logic [DAY_W-1:0] last_day_o
);
  always_comb begin
    unique case (mon_i)
      MON_W'(2):                                       last_day_o = leap_i ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11):     last_day_o = DAY_W'(30);
      default:                                         last_day_o = DAY_W'(31);
    endcase
  end
endmodule

// File: rtl/cal_time_step.sv
module cal_time_step
  import cal_pkg::*;
(
  input  hms_t cur_i,
  output hms_t nxt_o,
  output logic day_carry_o
);
  logic sec_wrap, min_wrap, hr_wrap;

  always_comb begin
    sec_wrap = (cur_i.sec >= SEC_W'(59));
    min_wrap = (cur_i.mn  >= MIN_W'(59));
    hr_wrap  = (cur_i.hr  >= HR_W'(23));
    nxt_o    = cur_i;
    day_carry_o = 1'b0;
    if (!sec_wrap) begin
      nxt_o.sec = cur_i.sec + SEC_W'(1);
    end else begin
      nxt_o.sec = '0;
      if (!min_wrap) begin
        nxt_o.mn = cur_i.mn + MIN_W'(1);
      end else begin
        nxt_o.mn = '0;
        if (!hr_wrap) begin
          nxt_o.hr = cur_i.hr + HR_W'(1);
        end else begin
          nxt_o.hr    = '0;
          day_carry_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
  import cal_pkg::*;
(
  input  ymd_t cur_i,
  output ymd_t nxt_o
);
  logic [DAY_W-1:0] last_day;
  logic [YR_W-1:0]  yr_inc;

  cal_month_days u_mdays (
    .mon_i      (cur_i.mon),
    .leap_i     (cur_i.leap),
    .last_day_o (last_day)
  );

  always_comb begin
    nxt_o  = cur_i;
    yr_inc = cur_i.yr + YR_W'(1);
    if (cur_i.day < last_day) begin
      nxt_o.day = cur_i.day + DAY_W'(1);
    end else begin
      nxt_o.day = DAY_W'(1);
      if (cur_i.mon < MON_W'(12) && cur_i.mon != '0) begin
        nxt_o.mon = cur_i.mon + MON_W'(1);
      end else begin
        nxt_o.mon  = MON_W'(1);
        nxt_o.yr   = yr_inc;
        nxt_o.leap = (yr_inc[1:0] == 2'b10);
      end
    end
  end
endmodule

// File: rtl/cal_commit_slot.sv
module cal_commit_slot #(
  parameter int W     = 16,
  parameter int TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic         commit_o,
  output logic [W-1:0] stage_o
);
  logic         busy_q, busy_d;
  logic [W-1:0] stage_q, stage_d;
  logic         accept, last_tick;

  assign accept = wr_i && !busy_q;

  generate
    if (TICKS > 1) begin : g_count
      localparam int CNT_W = $clog2(TICKS);
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;
      always_comb begin
        cnt_en = accept || (busy_q && tick_i);
        cnt_d  = accept ? '0 : cnt_q + CNT_W'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end
      assign last_tick = (cnt_q == CNT_W'(TICKS - 1));
    end else begin : g_single
      assign last_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    busy_d   = busy_q;
    stage_d  = stage_q;
    commit_o = 1'b0;
    if (accept) begin
      busy_d  = 1'b1;
      stage_d = wdata_i;
    end else if (busy_q && tick_i && last_tick) begin
      busy_d   = 1'b0;
      commit_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stage_q <= '0;
    end else begin
      busy_q  <= busy_d;
      stage_q <= stage_d;
    end
  end

  assign busy_o  = busy_q;
  assign stage_o = stage_q;

  // R6 / R7: busy persists until a tick arrives
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick_i |=> busy_q);
  // R8: a write while busy leaves the staged value untouched
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_i |=> stage_q == $past(stage_q));
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int COMMIT_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic hit_time, hit_date, hit_ctrl;
  assign hit_time = (addr_i == ADDR_W'(OFS_TIME));
  assign hit_date = (addr_i == ADDR_W'(OFS_DATE));
  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));

  logic [HMS_W-1:0] wr_hms;
  logic [YMD_W-1:0] wr_ymd;
  logic             unused_wbits;
  assign wr_hms = {wdata_i[20:16], wdata_i[13:8], wdata_i[5:0]};
  assign wr_ymd = {wdata_i[22], wdata_i[21:16], wdata_i[11:8], wdata_i[4:0]};
  assign unused_wbits = ^{wdata_i[31:23], wdata_i[15:14], wdata_i[7:6]};

  logic             busy_t, busy_d, commit_t, commit_d;
  logic [HMS_W-1:0] stage_t;
  logic [YMD_W-1:0] stage_d;

  cal_commit_slot #(.W(HMS_W), .TICKS(COMMIT_TICKS)) u_slot_time (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick_i   (tick_i),
    .wr_i     (wr_en_i && hit_time),
    .wdata_i  (wr_hms),
    .busy_o   (busy_t),
    .commit_o (commit_t),
    .stage_o  (stage_t)
  );

  cal_commit_slot #(.W(YMD_W), .TICKS(COMMIT_TICKS)) u_slot_date (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick_i   (tick_i),
    .wr_i     (wr_en_i && hit_date),
    .wdata_i  (wr_ymd),
    .busy_o   (busy_d),
    .commit_o (commit_d),
    .stage_o  (stage_d)
  );

  hms_t time_q, time_n, time_adv;
  ymd_t date_q, date_n, date_adv;
  logic day_carry;

  cal_time_step u_tstep (
    .cur_i       (time_q),
    .nxt_o       (time_adv),
    .day_carry_o (day_carry)
  );

  cal_date_step u_dstep (
    .cur_i (date_q),
    .nxt_o (date_adv)
  );

  always_comb begin
    time_n = time_q;
    date_n = date_q;
    if (commit_t)     time_n = hms_t'(stage_t);
    else if (tick_i)  time_n = time_adv;
    if (commit_d)                                  date_n = ymd_t'(stage_d);
    else if (tick_i && day_carry && !commit_t)     date_n = date_adv;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      time_q <= '0;
      date_q <= '{leap: 1'b0, yr: '0, mon: MON_W'(1), day: DAY_W'(1)};
    end else if (tick_i) begin
      time_q <= time_n;
      date_q <= date_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_time)      rdata_o = hms_to_word(time_q);
    else if (hit_date) rdata_o = ymd_to_word(date_q);
    else if (hit_ctrl) begin
      rdata_o[BIT_DATE_BUSY] = busy_d;
      rdata_o[BIT_TIME_BUSY] = busy_t;
      rdata_o[BIT_ALRM_BUSY] = 1'b0;
    end
  end

  // R11: no tick, no movement
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !tick_i |=> (time_q == $past(time_q)) && (date_q == $past(date_q)));
  // R3: plain second step
  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick_i && !commit_t && time_q.sec < SEC_W'(59) |=> time_q.sec == $past(time_q.sec) + SEC_W'(1));
  // R10: committed time lands unincremented
  p_time_load_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    commit_t |=> time_q == hms_t'($past(stage_t)));
  // R10: committed date wins over a carry
  p_date_load_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    commit_d |=> date_q == ymd_t'($past(stage_d)));
  // R5: leap flag follows the year when the year advances by counting
  p_leap_recalc_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick_i && !commit_d && !commit_t && day_carry && (date_adv.yr != date_q.yr)
      |=> date_q.leap == (date_q.yr[1:0] == 2'b10));
  // R4: a legal month stays legal when counting
  p_month_range_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !commit_d && date_q.mon >= MON_W'(1) && date_q.mon <= MON_W'(12)
      |=> date_q.mon >= MON_W'(1) && date_q.mon <= MON_W'(12));
endmodule

// File: tb/cal_timekeeper_tb.sv
module cal_timekeeper_tb;
  localparam int K = 2;

  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [7:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;

  cal_timekeeper #(.ADDR_W(8), .COMMIT_TICKS(K)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0] exp_q[$];
  logic [7:0]  adr_q[$];
  string       tag_q[$];

  // monitor: pops each expected item and compares away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      logic [7:0]  a;
      string       t;
      e = exp_q.pop_front();
      a = adr_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s: offset 0x%02h actual 0x%08h expected 0x%08h", t, a, rdata_o, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr_i = a;
    exp_q.push_back(e);
    adr_q.push_back(a);
    tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_tick();
    @(posedge clk); #1;
    tick_i = 1'b1;
    @(posedge clk); #1;
    tick_i = 1'b0;
  endtask

  task automatic set_time(input logic [31:0] v);
    wr(8'h14, v);
    for (int i = 0; i < K; i++) pulse_tick();
  endtask

  task automatic set_date(input logic [31:0] v);
    wr(8'h10, v);
    for (int i = 0; i < K; i++) pulse_tick();
  endtask

  // bring the clock to 23:59:59 and cross midnight
  task automatic cross_midnight();
    set_time(32'h00173B3B);
    pulse_tick();
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    expect_rd(8'h00, 32'h0, "R1 ctrl reset");
    expect_rd(8'h14, 32'h0, "R1 time reset");
    expect_rd(8'h10, 32'h00000101, "R1 date reset");

    for (int i = 0; i < 3; i++) pulse_tick();
    expect_rd(8'h14, 32'h3, "R3 three ticks");
    repeat (10) @(posedge clk);
    expect_rd(8'h14, 32'h3, "R11 hold without tick");

    wr(8'h14, 32'h00173B3A);
    expect_rd(8'h00, 32'h100, "R6 time busy set");
    expect_rd(8'h14, 32'h3, "R6 old time while busy");
    wr(8'h14, 32'h0);
    wr(8'h00, 32'h380);
    expect_rd(8'h00, 32'h100, "R9 ctrl write no effect");
    expect_rd(8'h20, 32'h0, "R9 unmapped reads zero");
    pulse_tick();
    expect_rd(8'h14, 32'h4, "R6 counting while busy");
    expect_rd(8'h00, 32'h100, "R6 busy before commit tick");
    pulse_tick();
    expect_rd(8'h14, 32'h00173B3A, "R10 R8 committed first value, not advanced");
    expect_rd(8'h00, 32'h0, "R6 busy cleared");

    pulse_tick();
    expect_rd(8'h14, 32'h00173B3B, "R3 23:59:59");
    pulse_tick();
    expect_rd(8'h14, 32'h0, "R3 midnight wrap");
    expect_rd(8'h10, 32'h00000102, "R3 day carry");

    set_time(32'h00173B3A);
    wr(8'h10, 32'h0005040A);
    expect_rd(8'h00, 32'h080, "R7 date busy set");
    pulse_tick();
    expect_rd(8'h10, 32'h00000102, "R7 old date while busy");
    pulse_tick();
    expect_rd(8'h14, 32'h0, "R10 time wrapped on commit tick");
    expect_rd(8'h10, 32'h0005040A, "R10 date commit wins over carry");
    expect_rd(8'h00, 32'h0, "R7 busy cleared");

    set_date(32'h0042021C);
    expect_rd(8'h10, 32'h0042021C, "R2 date layout");
    cross_midnight();
    expect_rd(8'h10, 32'h0042021D, "R4 leap Feb 29");
    cross_midnight();
    expect_rd(8'h10, 32'h00420301, "R4 leap Feb end");

    set_date(32'h0003021C);
    cross_midnight();
    expect_rd(8'h10, 32'h00030301, "R4 non-leap Feb end");

    set_date(32'h0005041E);
    cross_midnight();
    expect_rd(8'h10, 32'h00050501, "R4 30-day month");

    set_date(32'h0005011E);
    cross_midnight();
    expect_rd(8'h10, 32'h0005011F, "R4 day 31 exists in month 1");
    cross_midnight();
    expect_rd(8'h10, 32'h00050201, "R4 31-day month end");

    set_date(32'h00010C1F);
    cross_midnight();
    expect_rd(8'h10, 32'h00420101, "R5 year end sets leap");
    set_date(32'h00420C1F);
    cross_midnight();
    expect_rd(8'h10, 32'h00030101, "R5 year end clears leap");

    set_time(32'h00003B3B);
    pulse_tick();
    expect_rd(8'h14, 32'h00010000, "R3 hour carry");
    set_time(32'h0000003B);
    expect_rd(8'h14, 32'h0000003B, "R2 time layout");
    pulse_tick();
    expect_rd(8'h14, 32'h00000100, "R3 minute carry");

    wr(8'h14, 32'h00010203);
    wr(8'h10, 32'h00010203);
    expect_rd(8'h00, 32'h180, "R6 R7 both busy");

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule